// File: doc/BRIEF.md
# SPI Response Status Byte Generator

This block assembles the eight-bit status byte that a safety supervisor's SPI slave sends at the head of every frame. It collects single-cycle event pulses from the watchdog and from the error-signal monitor, and level inputs for the safe-state indication and a set of sticky interrupt sources. It also takes a verdict on each completed frame from the frame checker. At each frame start it freezes a new status byte, which an external shift register sends MSB first.

The three top bits always carry a fixed alternating guard so a data line shorted to ground or to supply shows up at once. Watchdog and monitor events are held in pending latches. Each event is reported in exactly one frame and is then dropped. The byte never changes while a frame is being shifted. A device reset clears every pending event and the stored verdict.

Top module: `spi_stat_gen`

## Requirements
- R1: Bits 7:5 of `statusByte` are always 1,0,1. After `rstN` is released, the byte reads 8'hA0.
- R2: Bit 4 takes the level of `safeState` in the cycle of a capture (`frameStart` high). The new byte is visible one clock later.
- R3: Bit 3 is the OR of all `intSrc` lines at capture. It stays 1 at every capture while any line is still high.
- R4: A `wdFail` pulse before a capture sets bit 2 in the byte of that capture. The next capture clears bit 2 if no new pulse arrived in between.
- R5: An `esmFail` pulse sets bit 1 with the same one-frame policy as R4.
- R6: An event pulse in the same cycle as a capture is not in that byte. It is reported by the following capture.
- R7: A `wdFail` pulse in a cycle where `wdCfgWrite` is high is ignored. Bit 2 stays 0 at the next capture.
- R8: Bit 0 at capture is 1 when the latest frame verdict was invalid (`frameEnd` with `frameValid` low). A valid verdict clears it. A verdict given in the same cycle as the capture is used by that capture.
- R9: `deviceReset` wins over capture and events. It clears the pending events and the verdict, and the byte reads 8'hA0 the next cycle.
- R10: `statusByte` changes only in the cycle after a capture or a `deviceReset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| deviceReset | input | 1 | device is entering its reset state |
| frameStart | input | 1 | chip-select fall, one-cycle capture strobe |
| frameEnd | input | 1 | frame finished, verdict on frameValid |
| frameValid | input | 1 | 1 when the ending frame was well formed |
| wdFail | input | 1 | watchdog failure pulse |
| wdCfgWrite | input | 1 | watchdog window configuration write |
| esmFail | input | 1 | error-signal-monitor failure pulse |
| safeState | input | 1 | device is in safe state |
| intSrc | input | INT_SRCS | sticky interrupt source levels |
| statusByte | output | 8 | frozen status byte for the current frame |

## Verification
Two events can land in the same cycle as a capture. One is an event pulse, which must be deferred to the next frame. The other is a frame verdict, which must be used by that capture. The bench drives each of these exactly on the `frameStart` cycle, checks the two consecutive bytes against literal values, and also drives `deviceReset` together with a capture and an event. A behavioural model runs alongside and compares every field on every clock.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam logic [2:0] GUARD_BITS = 3'b101;
  localparam logic [7:0] IDLE_BYTE = {GUARD_BITS, 5'b00000};

  typedef struct packed {
    logic capture;
    logic clearAll;
    logic wdArm;
    logic esmArm;
    logic verdictLoad;
    logic verdictBad;
  } statStrobe_t;
endpackage

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
(
  input  logic        deviceReset,
  input  logic        frameStart,
  input  logic        frameEnd,
  input  logic        frameValid,
  input  logic        wdFail,
  input  logic        wdCfgWrite,
  input  logic        esmFail,
  output statStrobe_t strb
);
  always_comb begin
    strb             = '0;
    strb.clearAll    = deviceReset;
    strb.capture     = frameStart && !deviceReset;
    strb.wdArm       = wdFail && !wdCfgWrite && !deviceReset;
    strb.esmArm      = esmFail && !deviceReset;
    strb.verdictLoad = frameEnd && !deviceReset;
    strb.verdictBad  = !frameValid;
  end
endmodule

// File: rtl/spi_stat_dp.sv
module spi_stat_dp
  import spi_stat_pkg::*;
#(
  parameter int INT_SRCS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  statStrobe_t         strb,
  input  logic                safeState,
  input  logic [INT_SRCS-1:0] intSrc,
  output logic [7:0]          statusByte,
  output logic                wdPendQ
);
  logic wdPend, esmPend, invFlag, invNext, anyInt;

  assign anyInt  = |intSrc;
  assign invNext = strb.verdictLoad ? strb.verdictBad : invFlag;
  assign wdPendQ = wdPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdPend     <= 1'b0;
      esmPend    <= 1'b0;
      invFlag    <= 1'b0;
      statusByte <= IDLE_BYTE;
    end else if (strb.clearAll) begin
      wdPend     <= 1'b0;
      esmPend    <= 1'b0;
      invFlag    <= 1'b0;
      statusByte <= IDLE_BYTE;
    end else begin
      invFlag <= invNext;
      if (strb.capture) begin
        statusByte <= {GUARD_BITS, safeState, anyInt, wdPend, esmPend, invNext};
        wdPend     <= strb.wdArm;
        esmPend    <= strb.esmArm;
      end else begin
        wdPend  <= wdPend  | strb.wdArm;
        esmPend <= esmPend | strb.esmArm;
      end
    end
  end

  a_r1_guard: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7:5] == 3'b101);

  a_r10_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capture && !strb.clearAll) |=> $stable(statusByte));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (statusByte == 8'hA0 && !wdPend && !esmPend && !invFlag));

  a_r4_pend_drop: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.wdArm) |=> !wdPend);
endmodule

// File: rtl/spi_stat_gen.sv
module spi_stat_gen
  import spi_stat_pkg::*;
#(
  parameter int INT_SRCS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                deviceReset,
  input  logic                frameStart,
  input  logic                frameEnd,
  input  logic                frameValid,
  input  logic                wdFail,
  input  logic                wdCfgWrite,
  input  logic                esmFail,
  input  logic                safeState,
  input  logic [INT_SRCS-1:0] intSrc,
  output logic [7:0]          statusByte
);
  statStrobe_t strb;
  logic        wdPendQ;

  spi_stat_ctrl u_ctrl (
    .deviceReset (deviceReset),
    .frameStart  (frameStart),
    .frameEnd    (frameEnd),
    .frameValid  (frameValid),
    .wdFail      (wdFail),
    .wdCfgWrite  (wdCfgWrite),
    .esmFail     (esmFail),
    .strb        (strb)
  );

  spi_stat_dp #(.INT_SRCS(INT_SRCS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .safeState  (safeState),
    .intSrc     (intSrc),
    .statusByte (statusByte),
    .wdPendQ    (wdPendQ)
  );

  a_r7_cfg_mask: assert property (@(posedge clk) disable iff (!rstN)
    (wdCfgWrite && !wdPendQ) |=> !wdPendQ);

  a_r8_bad_verdict: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && frameEnd && !frameValid && !deviceReset) |=> statusByte[0]);
endmodule

// File: tb/spi_stat_gen_bench.sv
module spi_stat_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic deviceReset = 0, frameStart = 0, frameEnd = 0, frameValid = 1;
  logic wdFail = 0, wdCfgWrite = 0, esmFail = 0, safeState = 0;
  logic [NSRC-1:0] intSrc = '0;
  logic [7:0] statusByte;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  spi_stat_gen #(.INT_SRCS(NSRC)) u_spi_stat_gen (
    .clk(clk), .rstN(rstN), .deviceReset(deviceReset), .frameStart(frameStart),
    .frameEnd(frameEnd), .frameValid(frameValid), .wdFail(wdFail),
    .wdCfgWrite(wdCfgWrite), .esmFail(esmFail), .safeState(safeState),
    .intSrc(intSrc), .statusByte(statusByte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit   mPendW = 0, mPendE = 0, mInv = 0;
  logic [7:0] mByte = 8'hA0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPendW = 0; mPendE = 0; mInv = 0; mByte = 8'hA0;
    end else if (deviceReset) begin
      mPendW = 0; mPendE = 0; mInv = 0; mByte = 8'hA0;
    end else begin
      bit newInv, armW;
      newInv = frameEnd ? !frameValid : mInv;
      armW = wdFail && !wdCfgWrite;
      if (frameStart) begin
        mByte = 8'hA0;
        if (safeState) mByte = mByte + 8'h10;
        if (intSrc != 0) mByte = mByte + 8'h08;
        if (mPendW) mByte = mByte + 8'h04;
        if (mPendE) mByte = mByte + 8'h02;
        if (newInv) mByte = mByte + 8'h01;
        mPendW = armW;
        mPendE = esmFail;
      end else begin
        mPendW = mPendW || armW;
        mPendE = mPendE || esmFail;
      end
      mInv = newInv;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      string tag;
      checks++;
      if (statusByte !== mByte) begin
        fails++;
        if (statusByte[7:5] !== mByte[7:5]) tag = "R1";
        else if (statusByte[4] !== mByte[4]) tag = "R2";
        else if (statusByte[3] !== mByte[3]) tag = "R3";
        else if (statusByte[2] !== mByte[2]) tag = "R4";
        else if (statusByte[1] !== mByte[1]) tag = "R5";
        else tag = "R8";
        $display("FAIL %s model compare: actual %h expected %h", tag, statusByte, mByte);
      end
    end
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic expect_byte(input logic [7:0] exp, input string tag);
    checks++;
    if (statusByte !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, statusByte, exp);
    end
  endtask

  // one cycle of strobes, returns at the next falling edge with inputs cleared
  task automatic step(input bit cap, input bit fe, input bit fv, input bit wd,
                      input bit cfg, input bit esm, input bit drst);
    @(negedge clk);
    frameStart = cap; frameEnd = fe; frameValid = fv; wdFail = wd;
    wdCfgWrite = cfg; esmFail = esm; deviceReset = drst;
    @(negedge clk);
    frameStart = 0; frameEnd = 0; frameValid = 1; wdFail = 0;
    wdCfgWrite = 0; esmFail = 0; deviceReset = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rstN = 1;
    idle(2);
    expect_byte(8'hA0, "R1 reset value");

    // R2 and R3: levels sampled at capture
    safeState = 1; intSrc = 4'b0100;
    step(1,0,1,0,0,0,0);
    expect_byte(8'hB8, "R2 R3 safe and interrupt");
    // R10: levels change without capture, byte holds
    safeState = 0; intSrc = 4'b0000;
    idle(3);
    expect_byte(8'hB8, "R10 hold between captures");
    intSrc = 4'b1001;
    step(1,0,1,0,0,0,0);
    expect_byte(8'hA8, "R3 interrupt still pending");
    intSrc = 0;
    step(1,0,1,0,0,0,0);
    expect_byte(8'hA0, "R3 interrupt cleared");

    // R4: watchdog event one frame then cleared
    step(0,0,1,1,0,0,0);
    idle(2);
    expect_byte(8'hA0, "R10 event mid-frame does not alter byte");
    step(1,0,1,0,0,0,0);
    expect_byte(8'hA4, "R4 watchdog reported");
    step(1,0,1,0,0,0,0);
    expect_byte(8'hA0, "R4 watchdog cleared");

    // R5: monitor event
    step(0,0,1,0,0,1,0);
    step(1,0,1,0,0,0,0);
    expect_byte(8'hA2, "R5 monitor reported");
    step(1,0,1,0,0,0,0);
    expect_byte(8'hA0, "R5 monitor cleared");

    // R6: event coinciding with capture is deferred
    step(1,0,1,1,0,1,0);
    expect_byte(8'hA0, "R6 coincident event deferred");
    step(1,0,1,0,0,0,0);
    expect_byte(8'hA6, "R6 deferred event reported");
    step(1,0,1,0,0,0,0);
    expect_byte(8'hA0, "R6 deferred event cleared");

    // R7: watchdog pulse during config write is ignored
    step(0,0,1,1,1,0,0);
    step(1,0,1,0,0,0,0);
    expect_byte(8'hA0, "R7 config write masks watchdog");

    // R8: frame verdicts
    step(0,1,0,0,0,0,0);
    step(1,0,1,0,0,0,0);
    expect_byte(8'hA1, "R8 invalid frame flagged");
    step(0,1,1,0,0,0,0);
    step(1,0,1,0,0,0,0);
    expect_byte(8'hA0, "R8 valid frame clears");
    step(1,1,0,0,0,0,0);
    expect_byte(8'hA1, "R8 same-cycle verdict used");
    step(1,1,1,0,0,0,0);
    expect_byte(8'hA0, "R8 same-cycle valid clears");

    // R9: device reset
    step(0,1,0,1,0,1,0);
    step(0,0,1,0,0,0,1);
    expect_byte(8'hA0, "R9 reset byte");
    step(1,0,1,0,0,0,0);
    expect_byte(8'hA0, "R9 pending and verdict dropped");
    safeState = 1;
    step(0,0,1,1,0,0,0);
    step(1,0,1,1,0,1,1);
    expect_byte(8'hA0, "R9 reset beats capture");
    step(1,0,1,0,0,0,0);
    expect_byte(8'hB0, "R9 reset beats coincident events");
    safeState = 0;
    idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule